// File: doc/BRIEF.md
# E3 Overhead Alarm Interrupt Monitor

This block sits behind an E3 receive framer that is already frame-aligned and uses the G.832 frame layout. The framer asserts a one-cycle frame strobe for each frame. In that same cycle it presents that frame's overhead indications: the trail trace byte, the remote block error bit, the remote defect (FERF) bit, the payload type field, and one flag each for a BIP-8 mismatch and a FA1/FA2 framing byte error. The monitor turns these indications into sticky interrupt status bits. All status bits live in one 8-bit register, and a read of that register clears it.

The remote defect bit passes through a persistence filter before it counts. The filter needs either 3 or 5 consecutive identical frames, chosen by a configuration input. Entry into the alarm and exit from the alarm both raise the same status bit. The current alarm level is also brought out on its own pin. A payload type change is judged against the frame just before, not against a provisioned value.

A separate writable enable register, with the same bit positions as the status register, selects which status bits drive the single combined interrupt output.

Top module: `e3oh_irq_mon`

## Requirements
- R1: After reset the status register, the enable register, `ferf_alarm` and `irq` are all 0. Status bits 7 and 5 always read 0.
- R2: Each used status bit stays 1 from its event until a read. A read is `stat_rd` high for one clock, and the clock edge that ends the read clears the register. `stat_rdata` shows the register contents continuously.
- R3: A frame whose trail trace byte has bit 7 equal to 1 sets status bit 6. A trail trace byte with bit 7 equal to 0 sets nothing.
- R4: A frame with the remote block error bit at 1 sets status bit 4.
- R5: When `ferf_long`=0, the alarm is declared once 3 consecutive frames carry a FERF bit of 1. When `ferf_long`=1, it takes 5. Declaration raises `ferf_alarm` and sets status bit 3. A 0 inside the run restarts the count.
- R6: While the alarm is active, it is cleared after 3 (or 5) consecutive frames with a FERF bit of 0. Clearing drops `ferf_alarm` and also sets status bit 3.
- R7: A frame with `bip_err`=1 sets status bit 2. A frame with `fa_err`=1 sets status bit 1.
- R8: A frame whose payload type differs from the previous frame's payload type sets status bit 0. The first frame after reset is never compared.
- R9: If an event for a bit falls in the same cycle as a read, that bit is 1 after the edge.
- R10: `irq_wr` loads `irq_wdata` into the enable register. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R11: While `frm_stb` is 0, all frame inputs are ignored. No status bit is set and the alarm level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One cycle per received frame; qualifies all frame inputs |
| trace_byte | input | 8 | Trail trace byte of the frame |
| febe_bit | input | 1 | Remote block error bit of the frame |
| ferf_bit | input | 1 | Remote defect bit of the frame |
| pld_type | input | 3 | Payload type field of the frame |
| bip_err | input | 1 | BIP-8 mismatch flag for the frame |
| fa_err | input | 1 | FA1/FA2 error flag for the frame |
| ferf_long | input | 1 | 0: 3-frame persistence, 1: 5-frame persistence |
| irq_wr | input | 1 | Write strobe for the enable register |
| irq_wdata | input | 8 | Enable register write data |
| stat_rd | input | 1 | Read strobe; clears the status register |
| stat_rdata | output | 8 | Status register contents |
| ferf_alarm | output | 1 | Current filtered remote defect alarm level |
| irq | output | 1 | OR of enabled status bits |

## Verification
The remote defect filter gets clean runs of exactly the threshold length, runs that are one frame short, and runs broken by a single opposite frame. Both persistence settings are used, which separates a correct count from an off-by-one and from a filter that does not restart. Payload type is held, changed, and presented first after reset, which tells a compare against the previous frame from a compare against a reset value. Reads are placed alone and on the same cycle as events, and frame inputs are toggled while the strobe is low. Together these expose a lost event and an unqualified input. A long pseudo-random mix of all inputs, enables and reads follows, checked against the model on every clock.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
   localparam int STAT_W = 8;
   // status bit positions (software decodes these)
   localparam int B_PLD  = 0;
   localparam int B_FA   = 1;
   localparam int B_BIP  = 2;
   localparam int B_FERF = 3;
   localparam int B_FEBE = 4;
   localparam int B_TTC  = 6;
   localparam logic [STAT_W-1:0] USED_MASK = 8'b0101_1111;
endpackage

// File: rtl/e3oh_ferf_filter.sv
module e3oh_ferf_filter #(
   parameter int SHORT_N = 3,
   parameter int LONG_N  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic ferf_in,
   input  logic use_long,
   output logic alarm,
   output logic change
);
   localparam int CNT_W = $clog2(LONG_N + 1);
   localparam logic [CNT_W-1:0] N_SHORT = CNT_W'(SHORT_N);
   localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(LONG_N);

   // run_q counts consecutive frames disagreeing with the current alarm level
   logic [CNT_W-1:0] run_q, run_d, need;
   logic             alarm_d;

   always_comb begin
      need    = use_long ? N_LONG : N_SHORT;
      run_d   = run_q;
      alarm_d = alarm;
      change  = 1'b0;
      if (stb) begin
         if (ferf_in == alarm) begin
            run_d = '0;
         end else if (run_q + 1'b1 >= need) begin
            run_d   = '0;
            alarm_d = ~alarm;
            change  = 1'b1;
         end else begin
            run_d = run_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         alarm <= 1'b0;
      end else begin
         run_q <= run_d;
         alarm <= alarm_d;
      end
   end

   AST_FERF_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(alarm)); // R11
   AST_FERF_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < N_LONG); // R5
   AST_FERF_CHANGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      change |=> (alarm != $past(alarm))); // R6
endmodule

// File: rtl/e3oh_evt_det.sv
module e3oh_evt_det
   import e3oh_pkg::*;
#(
   parameter int PT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              tr_msb,
   input  logic              febe,
   input  logic [PT_W-1:0]   pt,
   input  logic              bip_err,
   input  logic              fa_err,
   input  logic              ferf_chg,
   output logic [STAT_W-1:0] evt
);
   logic [PT_W-1:0] prev_pt_q;
   logic            pt_seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_pt_q <= '0;
         pt_seen_q <= 1'b0;
      end else if (stb) begin
         prev_pt_q <= pt;
         pt_seen_q <= 1'b1;
      end
   end

   always_comb begin
      evt         = '0;
      evt[B_TTC]  = stb & tr_msb;
      evt[B_FEBE] = stb & febe;
      evt[B_FERF] = ferf_chg;
      evt[B_BIP]  = stb & bip_err;
      evt[B_FA]   = stb & fa_err;
      evt[B_PLD]  = stb & pt_seen_q & (pt != prev_pt_q);
   end

   AST_NO_EVT_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |-> (evt == '0)); // R11
   AST_FIRST_FRAME_NO_PLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pt_seen_q |-> !evt[B_PLD]); // R8
endmodule

// File: rtl/e3oh_stat_reg.sv
module e3oh_stat_reg
   import e3oh_pkg::*;
#(
   parameter int              W    = STAT_W,
   parameter logic [W-1:0]    USED = USED_MASK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         rd,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] stat_q,
   output logic         irq
);
   logic [W-1:0] en_q;
   logic         unused_evt;

   assign unused_evt = ^(evt & ~USED);

   always_ff @(posedge clk) begin
      if (!rst_n)  en_q <= '0;
      else if (wr) en_q <= wdata & USED;
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (USED[b]) begin : g_used
         always_ff @(posedge clk) begin
            if (!rst_n) stat_q[b] <= 1'b0;
            else        stat_q[b] <= (stat_q[b] & ~rd) | evt[b];
         end
         AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[b] && !rd) |=> stat_q[b]); // R2
         AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && !evt[b]) |=> !stat_q[b]); // R2
         AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[b] |=> stat_q[b]); // R9
      end else begin : g_unused
         assign stat_q[b] = 1'b0;
      end
   end

   assign irq = |(stat_q & en_q);

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_q != '0)); // R10
endmodule

// File: rtl/e3oh_irq_mon.sv
module e3oh_irq_mon
   import e3oh_pkg::*;
#(
   parameter int TR_W       = 8,
   parameter int PT_W       = 3,
   parameter int FERF_SHORT = 3,
   parameter int FERF_LONG  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_stb,
   input  logic [TR_W-1:0]   trace_byte,
   input  logic              febe_bit,
   input  logic              ferf_bit,
   input  logic [PT_W-1:0]   pld_type,
   input  logic              bip_err,
   input  logic              fa_err,
   input  logic              ferf_long,
   input  logic              irq_wr,
   input  logic [STAT_W-1:0] irq_wdata,
   input  logic              stat_rd,
   output logic [STAT_W-1:0] stat_rdata,
   output logic              ferf_alarm,
   output logic              irq
);
   if (FERF_SHORT < 1 || FERF_SHORT >= FERF_LONG) begin : g_bad_persist
      $error("e3oh_irq_mon: need 1 <= FERF_SHORT < FERF_LONG");
   end
   if (TR_W < 2 || PT_W < 1) begin : g_bad_width
      $error("e3oh_irq_mon: field widths too small");
   end

   logic              ferf_chg;
   logic [STAT_W-1:0] evt;
   logic              unused_tr_bits;

   assign unused_tr_bits = ^trace_byte[TR_W-2:0];

   e3oh_ferf_filter #(.SHORT_N(FERF_SHORT), .LONG_N(FERF_LONG)) u_ferf (
      .clk(clk), .rst_n(rst_n), .stb(frm_stb), .ferf_in(ferf_bit),
      .use_long(ferf_long), .alarm(ferf_alarm), .change(ferf_chg)
   );

   e3oh_evt_det #(.PT_W(PT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .stb(frm_stb), .tr_msb(trace_byte[TR_W-1]),
      .febe(febe_bit), .pt(pld_type), .bip_err(bip_err), .fa_err(fa_err),
      .ferf_chg(ferf_chg), .evt(evt)
   );

   e3oh_stat_reg u_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .rd(stat_rd), .wr(irq_wr),
      .wdata(irq_wdata), .stat_q(stat_rdata), .irq(irq)
   );

   AST_ALARM_RISE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ferf_alarm) |-> stat_rdata[B_FERF]); // R5
   AST_ALARM_FALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ferf_alarm) |-> stat_rdata[B_FERF]); // R6
endmodule

// File: tb/e3oh_irq_mon_tb.sv
`timescale 1ns/1ps
module e3oh_irq_mon_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_stb = 0, febe_bit = 0, ferf_bit = 0, bip_err = 0, fa_err = 0;
   logic       ferf_long = 0, irq_wr = 0, stat_rd = 0;
   logic [7:0] trace_byte = 0, irq_wdata = 0;
   logic [2:0] pld_type = 0;
   logic [7:0] stat_rdata;
   logic       ferf_alarm, irq;

   always #2.5 clk = ~clk;

   e3oh_irq_mon u_dut (
      .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .trace_byte(trace_byte),
      .febe_bit(febe_bit), .ferf_bit(ferf_bit), .pld_type(pld_type),
      .bip_err(bip_err), .fa_err(fa_err), .ferf_long(ferf_long),
      .irq_wr(irq_wr), .irq_wdata(irq_wdata), .stat_rd(stat_rd),
      .stat_rdata(stat_rdata), .ferf_alarm(ferf_alarm), .irq(irq)
   );

   // behavioural reference
   int         n_vec = 0, n_miss = 0;
   logic [7:0] m_stat = 0, m_en = 0;
   logic       m_alarm = 0, m_seen = 0;
   logic [2:0] m_prev = 0;
   bit         hist[$];
   bit         done = 0;

   task automatic model_reset();
      m_stat = 0; m_en = 0; m_alarm = 0; m_seen = 0; m_prev = 0;
      hist.delete();
   endtask

   task automatic model_step();
      logic [7:0] ev;
      int         n;
      bit         all1, all0;
      ev = 0;
      if (frm_stb) begin
         if (trace_byte[7]) ev[6] = 1;
         if (febe_bit)      ev[4] = 1;
         if (bip_err)       ev[2] = 1;
         if (fa_err)        ev[1] = 1;
         if (m_seen && pld_type != m_prev) ev[0] = 1;
         m_prev = pld_type; m_seen = 1;
         hist.push_back(ferf_bit);
         if (hist.size() > 5) void'(hist.pop_front());
         n = ferf_long ? 5 : 3;
         if (hist.size() >= n) begin
            all1 = 1; all0 = 1;
            for (int i = hist.size() - n; i < hist.size(); i++)
               if (hist[i]) all0 = 0; else all1 = 0;
            if (!m_alarm && all1) begin m_alarm = 1; ev[3] = 1; end
            else if (m_alarm && all0) begin m_alarm = 0; ev[3] = 1; end
         end
      end
      m_stat = (stat_rd ? 8'h00 : m_stat) | ev;
      if (irq_wr) m_en = irq_wdata & 8'h5F;
   endtask

   task automatic compare(input string tag);
      n_vec++;
      if (stat_rdata !== m_stat) begin
         n_miss++;
         $display("FAIL %s status: got %02h expected %02h", tag, stat_rdata, m_stat);
      end
      if (ferf_alarm !== m_alarm) begin
         n_miss++;
         $display("FAIL %s ferf_alarm: got %b expected %b", tag, ferf_alarm, m_alarm);
      end
      if (irq !== |(m_stat & m_en)) begin
         n_miss++;
         $display("FAIL %s irq: got %b expected %b", tag, irq, |(m_stat & m_en));
      end
   endtask

   // inputs already set at a negedge; advance one clock and compare
   task automatic step(input string tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
      frm_stb = 0; stat_rd = 0; irq_wr = 0;
      compare(tag);
   endtask

   task automatic frame(input logic [7:0] tr, input logic fb, input logic ff,
                        input logic [2:0] pt, input logic be, input logic fe,
                        input string tag);
      frm_stb = 1; trace_byte = tr; febe_bit = fb; ferf_bit = ff;
      pld_type = pt; bip_err = be; fa_err = fe;
      step(tag);
      trace_byte = 0; febe_bit = 0; bip_err = 0; fa_err = 0;
   endtask

   task automatic rd(input string tag);
      stat_rd = 1;
      step(tag);
   endtask

   task automatic ferf_frames(input logic v, input int cnt, input string tag);
      for (int i = 0; i < cnt; i++) frame(8'h00, 0, v, 3'd1, 0, 0, tag);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_miss++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2468;
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
      compare("R1 reset");
      step("R1 idle");

      // R8: first frame not compared, then change vs previous
      frame(8'h00, 0, 0, 3'd5, 0, 0, "R8 first frame");
      frame(8'h00, 0, 0, 3'd5, 0, 0, "R8 same type");
      frame(8'h00, 0, 0, 3'd2, 0, 0, "R8 changed type");
      rd("R2 read clears");
      // R3
      frame(8'h7F, 0, 0, 3'd2, 0, 0, "R3 msb zero");
      frame(8'h80, 0, 0, 3'd2, 0, 0, "R3 msb one");
      step("R2 hold");
      step("R2 hold");
      rd("R2 read");
      // R4, R7
      frame(8'h00, 1, 0, 3'd2, 0, 0, "R4 febe");
      frame(8'h00, 0, 0, 3'd2, 1, 0, "R7 bip");
      frame(8'h00, 0, 0, 3'd2, 0, 1, "R7 fa");
      rd("R2 read");
      // R11: inputs toggling while strobe low
      trace_byte = 8'hFF; febe_bit = 1; ferf_bit = 1; bip_err = 1; fa_err = 1;
      pld_type = 3'd7;
      for (int i = 0; i < 6; i++) step("R11 no strobe");
      trace_byte = 0; febe_bit = 0; ferf_bit = 0; bip_err = 0; fa_err = 0;
      // R9: event and read together
      frame(8'h00, 1, 0, 3'd2, 0, 0, "R9 setup");
      stat_rd = 1;
      frame(8'h00, 0, 0, 3'd2, 1, 0, "R9 event with read");
      rd("R9 clear");
      // R10: enables
      irq_wdata = 8'h04; irq_wr = 1; step("R10 enable bip");
      frame(8'h00, 1, 0, 3'd2, 0, 0, "R10 disabled source");
      frame(8'h00, 0, 0, 3'd2, 1, 0, "R10 enabled source");
      rd("R10 clear");
      irq_wdata = 8'hFF; irq_wr = 1; step("R10 enable all");
      // R5/R6 short persistence
      ferf_long = 0;
      ferf_frames(1, 2, "R5 short run");
      frame(8'h00, 0, 0, 3'd1, 0, 0, "R5 break");
      rd("R5 clear pld");
      ferf_frames(1, 3, "R5 declare 3");
      rd("R5 read");
      ferf_frames(0, 2, "R6 short run");
      ferf_frames(1, 1, "R6 break");
      ferf_frames(0, 3, "R6 clear 3");
      rd("R6 read");
      // long persistence
      ferf_long = 1;
      ferf_frames(1, 4, "R5 long short run");
      ferf_frames(0, 1, "R5 long break");
      ferf_frames(1, 5, "R5 declare 5");
      rd("R5 read");
      ferf_frames(0, 4, "R6 long short run");
      ferf_frames(0, 1, "R6 clear 5");
      rd("R6 read");

      // pseudo-random mix
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         frm_stb    = lfsr[0] | lfsr[1];
         trace_byte = lfsr[15:8] & {lfsr[3], 7'h7F};
         febe_bit   = lfsr[16] & lfsr[17] & lfsr[18];
         bip_err    = lfsr[19] & lfsr[20] & lfsr[2];
         fa_err     = lfsr[21] & lfsr[22] & lfsr[4];
         if (lfsr[7:4] == 4'd0) ferf_bit = ~ferf_bit;
         if (lfsr[11:9] == 3'd0) pld_type = lfsr[14:12];
         stat_rd    = (lfsr[25:23] == 3'd0);
         irq_wr     = (lfsr[30:27] == 4'd0);
         irq_wdata  = lfsr[31:24];
         if (lfsr[31:26] == 6'd0) ferf_long = ~ferf_long;
         step("MIX R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end
endmodule